// File: doc/BRIEF.md
# Nested-Loop Descriptor DMA Engine

A single data-movement engine serves up to `NCH` channels. Each channel's transfer descriptor lives in an internal descriptor store. A register-style programming port writes that store one field at a time. A start pulse on a channel marks the channel active. The engine then walks the active channels one at a time, always taking the lowest-numbered one first. For the selected channel it runs one complete inner loop of elements. Each element is a read from the source address followed by a write of the same data to the destination address, carried over one shared memory master port with a ready handshake.

After every element both addresses step by signed per-channel offsets. When an inner loop ends, each address also takes a signed end-of-loop adjustment. The outer-loop count is decremented and written back to the descriptor together with the advanced addresses, and the engine re-arbitrates. When the outer count reaches zero, the channel drops out of the active set and pulses its done output. A descriptor with misaligned addresses or steps, or with a zero loop count, is rejected before any memory access and pulses the channel's error output.

Top module: `dma_nested_engine`

## Requirements
- R1: While reset is asserted and after it is released, the engine issues no memory request and holds `done_o` and `err_o` low until a channel is started.
- R2: A write on the programming port sets one field of channel `cfg_ch_i`'s descriptor. The field codes are: 0 source address, 1 destination address, 2 offsets {destination[31:16], source[15:0]} (signed 16-bit each), 3 source end-of-loop adjustment, 4 destination end-of-loop adjustment (signed 32-bit each), 5 inner element count[15:0], 6 outer loop count[15:0], 7 element size code[1:0].
- R3: Each element is exactly one read at the current source address, followed by one write at the current destination address. The write carries the data returned by that read.
- R4: The size code selects the element width as 1 << code bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes). The code is presented on `mem_size_o` with every access, and every access address is a multiple of that width.
- R5: After every element, the source address advances by the sign-extended source offset and the destination address advances by the sign-extended destination offset.
- R6: After the last element of an inner loop, the source and destination end-of-loop adjustments are added on top of the per-element offsets.
- R7: Each completed inner loop decrements the outer count by one. When the count reaches zero, the channel's `done_o` bit pulses for one cycle and the channel is no longer serviced.
- R8: Among active channels, the lowest-numbered one is serviced. Arbitration happens only between whole inner loops.
- R9: If the source address, destination address, either offset or either adjustment is not a multiple of the element width, the channel's `err_o` bit pulses. No memory access is made and the channel is deactivated.
- R10: A start with a zero inner count or a zero outer count is rejected the same way as in R9.
- R11: A request with `mem_ready_i` low stays asserted next cycle with unchanged address and direction.
- R12: The advanced addresses and the outer count are written back to the descriptor. Reloading only the outer count and starting again continues from where the previous run stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Descriptor field write strobe |
| cfg_ch_i | input | CHW | Channel whose descriptor is written |
| cfg_field_i | input | 3 | Field code (see R2) |
| cfg_wdata_i | input | 32 | Field value |
| start_i | input | NCH | Per-channel start pulses |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access address |
| mem_size_o | output | 2 | Element size code |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ready on reads |
| mem_ready_i | input | 1 | Access accepted this cycle |
| done_o | output | NCH | Per-channel completion pulse |
| err_o | output | NCH | Per-channel rejection pulse |

## Verification
A start pulse reaches the first read request four clock edges later: the active flag, the grant, the descriptor load and the check each take one edge. A rejection pulse appears on `err_o` after that same fourth edge. A done pulse follows two edges after the final write handshake. Because the memory model stalls every third cycle, data results are not tied to fixed cycles. The monitor compares each access at the edge where request and ready are both high, in order, against a queue that the driver fills from the requirements. Done and error pulses are counted per channel and checked only after the queue has drained and a settling window has passed.

// File: rtl/dma_pkg.sv
package dma_pkg;
  parameter int AW = 32;
  parameter int OW = 16;
  parameter int CW = 16;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CHK, S_RD, S_WR, S_WB} eng_state_e;

  localparam logic [2:0] F_SRC   = 3'd0;
  localparam logic [2:0] F_DST   = 3'd1;
  localparam logic [2:0] F_OFF   = 3'd2;
  localparam logic [2:0] F_SADJ  = 3'd3;
  localparam logic [2:0] F_DADJ  = 3'd4;
  localparam logic [2:0] F_INNER = 3'd5;
  localparam logic [2:0] F_OUTER = 3'd6;
  localparam logic [2:0] F_SIZE  = 3'd7;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [OW-1:0] soff;
    logic [OW-1:0] doff;
    logic [AW-1:0] sadj;
    logic [AW-1:0] dadj;
    logic [CW-1:0] inner;
    logic [CW-1:0] outer;
    logic [1:0]    size;
  } desc_t;
endpackage

// File: rtl/dma_lowest_arb.sv
module dma_lowest_arb #(
  parameter int NCH = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  output logic           gnt_valid_o,
  output logic [CHW-1:0] gnt_idx_o
);
  localparam logic [NCH-1:0] ONE_N = 1;

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = i[CHW-1:0];
      end
    end
  end

  p_lowest_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (req_i[gnt_idx_o] && ((req_i & ((ONE_N << gnt_idx_o) - ONE_N)) == '0)));
  p_grant_when_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> gnt_valid_o);
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_pkg::*;
(
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [OW-1:0] soff_i,
  input  logic [OW-1:0] doff_i,
  input  logic [AW-1:0] sadj_i,
  input  logic [AW-1:0] dadj_i,
  input  logic [1:0]    size_i,
  input  logic          last_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          misaligned_o
);
  localparam logic [AW-1:0] ONE_A = 1;
  logic [AW-1:0] msk, soff_x, doff_x;

  always_comb begin
    msk    = (ONE_A << size_i) - ONE_A;
    soff_x = {{(AW-OW){soff_i[OW-1]}}, soff_i};
    doff_x = {{(AW-OW){doff_i[OW-1]}}, doff_i};
    src_o  = src_i + soff_x + (last_i ? sadj_i : '0);
    dst_o  = dst_i + doff_x + (last_i ? dadj_i : '0);
    misaligned_o = |((src_i | dst_i | soff_x | doff_x | sadj_i | dadj_i) & msk);
  end
endmodule

// File: rtl/dma_nested_engine.sv
module dma_nested_engine
  import dma_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 64,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [2:0]     cfg_field_i,
  input  logic [31:0]    cfg_wdata_i,
  input  logic [NCH-1:0] start_i,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [1:0]     mem_size_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ready_i,
  output logic [NCH-1:0] done_o,
  output logic [NCH-1:0] err_o
);
  localparam logic [CW-1:0]  ONE_C = 1;
  localparam logic [AW-1:0]  ONE_A = 1;
  localparam logic [NCH-1:0] ONE_N = 1;

  desc_t          desc_q [NCH];
  eng_state_e     st_q;
  logic [NCH-1:0] act_q, clr, done_d, err_d;
  logic [CHW-1:0] ch_q, gnt_idx;
  logic           gnt_valid;
  logic [AW-1:0]  src_q, dst_q, sadj_q, dadj_q, nsrc, ndst;
  logic [OW-1:0]  soff_q, doff_q;
  logic [CW-1:0]  inner_q, left_q, outer_q, outer_nx;
  logic [1:0]     size_q;
  logic [DW-1:0]  data_q;
  logic           misal, last_el, hs;

  dma_lowest_arb #(.NCH(NCH)) u_arb (
    .clk_i, .rst_ni, .req_i(act_q), .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx)
  );

  assign last_el = (left_q == ONE_C);

  dma_addr_step u_step (
    .src_i(src_q), .dst_i(dst_q), .soff_i(soff_q), .doff_i(doff_q),
    .sadj_i(sadj_q), .dadj_i(dadj_q), .size_i(size_q), .last_i(last_el),
    .src_o(nsrc), .dst_o(ndst), .misaligned_o(misal)
  );

  assign mem_req_o   = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we_o    = (st_q == S_WR);
  assign mem_addr_o  = (st_q == S_WR) ? dst_q : src_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = data_q;
  assign hs          = mem_req_o && mem_ready_i;
  assign outer_nx    = outer_q - ONE_C;

  always_comb begin
    clr    = '0;
    done_d = '0;
    err_d  = '0;
    if (st_q == S_CHK && (misal || inner_q == '0 || outer_q == '0)) begin
      clr[ch_q]   = 1'b1;
      err_d[ch_q] = 1'b1;
    end
    if (st_q == S_WB && outer_nx == '0) begin
      clr[ch_q]    = 1'b1;
      done_d[ch_q] = 1'b1;
    end
  end

  // descriptor store: engine write-back has priority over programming
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) desc_q[i] <= '0;
    end else begin
      if (cfg_we_i) begin
        case (cfg_field_i)
          F_SRC:   desc_q[cfg_ch_i].src   <= cfg_wdata_i;
          F_DST:   desc_q[cfg_ch_i].dst   <= cfg_wdata_i;
          F_OFF:   begin
            desc_q[cfg_ch_i].soff <= cfg_wdata_i[15:0];
            desc_q[cfg_ch_i].doff <= cfg_wdata_i[31:16];
          end
          F_SADJ:  desc_q[cfg_ch_i].sadj  <= cfg_wdata_i;
          F_DADJ:  desc_q[cfg_ch_i].dadj  <= cfg_wdata_i;
          F_INNER: desc_q[cfg_ch_i].inner <= cfg_wdata_i[15:0];
          F_OUTER: desc_q[cfg_ch_i].outer <= cfg_wdata_i[15:0];
          default: desc_q[cfg_ch_i].size  <= cfg_wdata_i[1:0];
        endcase
      end
      if (st_q == S_WB) begin
        desc_q[ch_q].src   <= src_q;
        desc_q[ch_q].dst   <= dst_q;
        desc_q[ch_q].outer <= outer_nx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      act_q  <= '0;
      done_o <= '0;
      err_o  <= '0;
      ch_q   <= '0;
      src_q  <= '0;  dst_q  <= '0;
      soff_q <= '0;  doff_q <= '0;
      sadj_q <= '0;  dadj_q <= '0;
      inner_q <= '0; left_q <= '0; outer_q <= '0;
      size_q <= '0;
      data_q <= '0;
    end else begin
      act_q  <= (act_q & ~clr) | start_i;
      done_o <= done_d;
      err_o  <= err_d;
      case (st_q)
        S_IDLE: if (gnt_valid) begin
          ch_q <= gnt_idx;
          st_q <= S_LOAD;
        end
        S_LOAD: begin
          src_q   <= desc_q[ch_q].src;
          dst_q   <= desc_q[ch_q].dst;
          soff_q  <= desc_q[ch_q].soff;
          doff_q  <= desc_q[ch_q].doff;
          sadj_q  <= desc_q[ch_q].sadj;
          dadj_q  <= desc_q[ch_q].dadj;
          inner_q <= desc_q[ch_q].inner;
          left_q  <= desc_q[ch_q].inner;
          outer_q <= desc_q[ch_q].outer;
          size_q  <= desc_q[ch_q].size;
          st_q    <= S_CHK;
        end
        S_CHK: st_q <= (|err_d) ? S_IDLE : S_RD;
        S_RD: if (hs) begin
          data_q <= mem_rdata_i;
          st_q   <= S_WR;
        end
        S_WR: if (hs) begin
          src_q  <= nsrc;
          dst_q  <= ndst;
          left_q <= left_q - ONE_C;
          st_q   <= last_el ? S_WB : S_RD;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_idle_no_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == '0 && st_q == S_IDLE) |-> !mem_req_o);
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  p_rd_then_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_req_o && mem_we_o));
  p_wr_not_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i) |=> !(mem_req_o && mem_we_o));
  p_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_addr_o & ((ONE_A << mem_size_o) - ONE_A)) == '0));
  p_one_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o | err_o));
  p_done_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_o | err_o) != '0 && start_i == '0) |-> ((act_q & (done_o | err_o)) == '0));
  p_err_no_access_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_d != '0) |=> !mem_req_o);
endmodule

// File: tb/dma_nested_engine_test.sv
module dma_nested_engine_test;
  localparam int NCH = 32;
  localparam int DW  = 64;
  localparam int CHW = $clog2(NCH);

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cfg_we_i = 1'b0;
  logic [CHW-1:0] cfg_ch_i = '0;
  logic [2:0]     cfg_field_i = '0;
  logic [31:0]    cfg_wdata_i = '0;
  logic [NCH-1:0] start_i = '0;
  logic           mem_req_o, mem_we_o;
  logic [31:0]    mem_addr_o;
  logic [1:0]     mem_size_o;
  logic [DW-1:0]  mem_wdata_o;
  logic [DW-1:0]  mem_rdata_i = '0;
  logic           mem_ready_i = 1'b0;
  logic [NCH-1:0] done_o, err_o;

  dma_nested_engine #(.NCH(NCH), .DW(DW)) uut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  int done_cnt [NCH];
  int err_cnt  [NCH];
  string cur_req = "R3";
  logic [98:0] exp_q [$];   // {we, size, addr, data}
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: ready pattern, read data, handshake comparison, pulse tallies
  always @(negedge clk_i) begin
    cyc++;
    mem_ready_i = (cyc % 3) != 0;
    if (mem_req_o && !mem_we_o) mem_rdata_i = {~mem_addr_o, mem_addr_o};
    for (int c = 0; c < NCH; c++) begin
      if (done_o[c]) done_cnt[c]++;
      if (err_o[c])  err_cnt[c]++;
    end
    if (rst_ni && mem_req_o && mem_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected access", {31'd0, mem_we_o, mem_addr_o}, 64'd0);
      end else begin
        logic [98:0] e;
        e = exp_q.pop_front();
        chk(mem_we_o == e[98], {cur_req, " direction"}, {63'd0, mem_we_o}, {63'd0, e[98]});
        chk(mem_addr_o == e[95:64], {cur_req, " address"}, {32'd0, mem_addr_o}, {32'd0, e[95:64]});
        chk(mem_size_o == e[97:96], "R4 size", {62'd0, mem_size_o}, {62'd0, e[97:96]});
        if (e[98]) chk(mem_wdata_o == e[63:0], "R3 data", mem_wdata_o, e[63:0]);
      end
    end
  end

  task automatic wr_field(input int ch, input logic [2:0] f, input logic [31:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_ch_i = ch[CHW-1:0]; cfg_field_i = f; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // R2: field codes 0..7
  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d, input int so, input int dof,
                      input int sa, input int da, input int inn, input int out, input int sz);
    wr_field(ch, 3'd0, s);
    wr_field(ch, 3'd1, d);
    wr_field(ch, 3'd2, {dof[15:0], so[15:0]});
    wr_field(ch, 3'd3, sa);
    wr_field(ch, 3'd4, da);
    wr_field(ch, 3'd5, inn);
    wr_field(ch, 3'd6, out);
    wr_field(ch, 3'd7, sz);
  endtask

  // driver: expected access stream from R3, R5, R6, R7
  task automatic expect_run(inout logic [31:0] s, inout logic [31:0] d, input int so, input int dof,
                            input int sa, input int da, input int inn, input int out, input int sz);
    for (int o = 0; o < out; o++) begin
      for (int i = 0; i < inn; i++) begin
        exp_q.push_back({1'b0, sz[1:0], s, 64'd0});
        exp_q.push_back({1'b1, sz[1:0], d, ~s, s});
        s = s + so;
        d = d + dof;
        if (i == inn - 1) begin
          s = s + sa;
          d = d + da;
        end
      end
    end
  endtask

  task automatic kick(input logic [NCH-1:0] m);
    @(negedge clk_i);
    start_i = m;
    @(negedge clk_i);
    start_i = '0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(negedge clk_i);
      t++;
    end
    chk(exp_q.size() == 0, {cur_req, " pending accesses"}, exp_q.size(), 0);
    repeat (12) @(negedge clk_i);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] s3, d3, s, d;
    for (int c = 0; c < NCH; c++) begin done_cnt[c] = 0; err_cnt[c] = 0; end
    repeat (3) @(negedge clk_i);
    // R1: quiet during reset
    chk(!mem_req_o && done_o == '0 && err_o == '0, "R1 in reset", {62'd0, mem_req_o, |done_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!mem_req_o && done_o == '0 && err_o == '0, "R1 after reset", {62'd0, mem_req_o, |err_o}, 0);

    // R5 R6 R7: 4-byte elements, 3 per inner loop, 2 outer loops
    cur_req = "R6";
    prog(3, 32'h1000, 32'h2000, 4, 8, 32'h100, -16, 3, 2, 2);
    s3 = 32'h1000; d3 = 32'h2000;
    expect_run(s3, d3, 4, 8, 32'h100, -16, 3, 2, 2);
    kick(1 << 3);
    drain();
    chk(done_cnt[3] == 1, "R7 done once", done_cnt[3], 1);
    chk(err_cnt[3] == 0, "R7 no error", err_cnt[3], 0);

    // R12: reload only outer count, continue from written-back addresses
    cur_req = "R12";
    wr_field(3, 3'd6, 1);
    expect_run(s3, d3, 4, 8, 32'h100, -16, 3, 1, 2);
    kick(1 << 3);
    drain();
    chk(done_cnt[3] == 2, "R12 second done", done_cnt[3], 2);

    // R10 via exhausted outer count on the same channel
    cur_req = "R10";
    kick(1 << 3);
    drain();
    chk(err_cnt[3] == 1, "R10 exhausted outer", err_cnt[3], 1);

    // R5 R4: 8-byte elements, negative source offset
    cur_req = "R5";
    prog(7, 32'h8000, 32'h9000, -8, 16, 64, -8, 2, 3, 3);
    s = 32'h8000; d = 32'h9000;
    expect_run(s, d, -8, 16, 64, -8, 2, 3, 3);
    kick(1 << 7);
    drain();
    chk(done_cnt[7] == 1, "R7 ch7 done", done_cnt[7], 1);

    // R4: byte elements at odd addresses
    cur_req = "R4";
    prog(0, 32'h3001, 32'h4003, 1, -1, 5, 7, 4, 1, 0);
    s = 32'h3001; d = 32'h4003;
    expect_run(s, d, 1, -1, 5, 7, 4, 1, 0);
    kick(1 << 0);
    drain();
    chk(done_cnt[0] == 1, "R4 ch0 done", done_cnt[0], 1);

    // R8: simultaneous start, lower channel runs to completion first
    cur_req = "R8";
    prog(9, 32'h500, 32'h600, 4, 4, 0, 0, 1, 2, 2);
    prog(1, 32'h100, 32'h200, 2, 2, 0, 0, 2, 2, 1);
    s = 32'h100; d = 32'h200;
    expect_run(s, d, 2, 2, 0, 0, 2, 2, 1);
    s = 32'h500; d = 32'h600;
    expect_run(s, d, 4, 4, 0, 0, 1, 2, 2);
    kick((1 << 9) | (1 << 1));
    drain();
    chk(done_cnt[1] == 1 && done_cnt[9] == 1, "R8 both done", {done_cnt[1], done_cnt[9]}, {32'd1, 32'd1});

    // R9: misaligned source address, then misaligned offset
    cur_req = "R9";
    prog(4, 32'h1002, 32'h2000, 4, 4, 0, 0, 1, 1, 2);
    kick(1 << 4);
    drain();
    chk(err_cnt[4] == 1 && done_cnt[4] == 0, "R9 address", {err_cnt[4], done_cnt[4]}, {32'd1, 32'd0});
    prog(5, 32'h1000, 32'h2000, 4, 8, 0, 0, 1, 1, 3);
    kick(1 << 5);
    drain();
    chk(err_cnt[5] == 1 && done_cnt[5] == 0, "R9 offset", {err_cnt[5], done_cnt[5]}, {32'd1, 32'd0});

    // R10: zero inner count, zero outer count
    cur_req = "R10";
    prog(6, 32'h1000, 32'h2000, 4, 4, 0, 0, 0, 1, 2);
    prog(8, 32'h1000, 32'h2000, 4, 4, 0, 0, 1, 0, 2);
    kick((1 << 6) | (1 << 8));
    drain();
    chk(err_cnt[6] == 1 && err_cnt[8] == 1, "R10 zero counts", {err_cnt[6], err_cnt[8]}, {32'd1, 32'd1});

    // R11/R1: engine idle again, no stray activity
    chk(!mem_req_o && done_o == '0, "R11 idle at end", {63'd0, mem_req_o}, 0);

    finished = 1'b1;
    report();
  end
endmodule